// File: doc/BRIEF.md
# Maskable Interrupt Status Controller

This block gathers event pulses from a network controller's receive, transmit, statistics-counter and remote-DMA logic into one byte-wide interrupt status register. The host masks the events through a seven-bit enable register and drives a single registered interrupt request line. The host reads the status byte to find out which events are pending. To acknowledge them, it writes back a byte with ones in the positions it wants cleared.

The top bit of the status byte is not a latched event. It is a live copy of the controller's stopped state, registered once. It has no enable bit, ignores writes and never raises the interrupt line. The block does not contain the event sources or the stop sequencing itself. It only collects their strobes and the stopped level.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset the status byte reads 0x80 (bits 0 to 6 clear, bit 7 set), the mask byte reads 0x00 and `irq_o` is low.
- R2: A one on `evt_i[k]` at a rising clock edge sets status bit k from that edge on. The bit stays set until the host clears it. Bit positions: 0 receive ok, 1 transmit ok, 2 receive error, 3 transmit error, 4 ring overwrite warning, 5 counter overflow, 6 remote DMA done.
- R3: A write with `reg_addr_i` = 0 (status) clears exactly the status bits whose `reg_wdata_i` bit is one. Bits written as zero keep their value, and writing 0xFF clears bits 0 to 6.
- R4: When an event strobe and a write-one-to-clear hit the same status bit at the same edge, the bit ends up set.
- R5: A write with `reg_addr_i` = 1 (mask) loads bits 0 to 6 of the data into the mask. Reading the mask returns those seven bits with bit 7 always zero.
- R6: `irq_o` is high one clock after a cycle in which some status bit k in 0 to 6 and mask bit k are both one. It is low one clock after a cycle in which no such pair exists.
- R7: While the mask is all zero, `irq_o` stays low even with status bits pending.
- R8: Reading the status byte returns every pending bit, independent of the mask contents.
- R9: Status bit 7 equals the `stopped_i` level sampled at the previous clock edge. Writes do not change it, and it never drives `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 7 | Event strobes, one per status bit 0 to 6 |
| stopped_i | input | 1 | Controller stopped level |
| reg_addr_i | input | 1 | Register select: 0 status, 1 mask |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Read data of the selected register (combinational) |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with its default of seven maskable event bits, so every bit position of both registers and the unmasked stopped bit are reachable. Random events, clear writes, mask writes and stop-level changes run against a cycle model. These runs reach collisions between a set and a clear on the same bit, and mask changes landing in the same cycle as events. Directed steps pin down the one-cycle lag of the interrupt line and the all-zero mask case.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_MASK   = 1'b1
    } reg_sel_e;

endpackage

// File: rtl/irq_evt_latch.sv
module irq_evt_latch #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] status_o
);

    typedef struct packed {
        logic [W-1:0] bits;
    } latch_t;

    latch_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // set wins over clear on the same bit
        st_d.bits = (st_q.bits & ~clr_i) | evt_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o = st_q.bits;

    // R2 / R4: every strobed bit is set after the edge
    a_r4_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((st_q.bits & $past(evt_i)) == $past(evt_i)));

    // R3: bits cleared without a competing event go to zero
    a_r3_clear_exact: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_i & ~evt_i)) |=> ((st_q.bits & $past(clr_i & ~evt_i)) == '0));

    // R3: bits not written as one keep their value
    a_r3_keep_unwritten: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(st_q.bits) & ~$past(clr_i) & ~st_q.bits) == '0));

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] mask_o
);

    typedef struct packed {
        logic [W-1:0] en;
    } mask_t;

    mask_t mk_d, mk_q;

    always_comb begin
        mk_d = mk_q;
        if (wr_i) begin
            mk_d.en = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mk_q <= '0;
        end else begin
            mk_q <= mk_d;
        end
    end

    assign mask_o = mk_q.en;

    // R5: mask holds when not written
    a_r5_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(mk_q.en));

endmodule

// File: rtl/irq_req_gen.sv
module irq_req_gen #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] status_i,
    input  logic [W-1:0] mask_i,
    output logic         irq_o
);

    typedef struct packed {
        logic req;
    } req_t;

    req_t rq_d, rq_q;

    always_comb begin
        rq_d     = rq_q;
        rq_d.req = |(status_i & mask_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rq_q <= '0;
        end else begin
            rq_q <= rq_d;
        end
    end

    assign irq_o = rq_q.req;

    // R6: request follows masked status with one cycle of lag
    a_r6_irq_lag: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (rq_q.req == $past(|(status_i & mask_i))));

    // R7: an all-zero mask keeps the line low
    a_r7_no_mask_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_i == '0) |=> !rq_q.req);

endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl #(
    parameter int EVT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_W-1:0] evt_i,
    input  logic             stopped_i,
    input  logic             reg_addr_i,
    input  logic             reg_we_i,
    input  logic [EVT_W:0]   reg_wdata_i,
    output logic [EVT_W:0]   reg_rdata_o,
    output logic             irq_o
);

    import irq_ctl_pkg::*;

    localparam int BYTE_W = EVT_W + 1;

    typedef struct packed {
        logic stop;
    } top_t;

    top_t tp_d, tp_q;

    reg_sel_e          sel;
    logic [EVT_W-1:0]  clr_vec;
    logic              mask_wr;
    logic [EVT_W-1:0]  status_bits;
    logic [EVT_W-1:0]  mask_bits;
    logic [BYTE_W-1:0] rd_mux;

    assign sel = reg_sel_e'(reg_addr_i);

    always_comb begin
        tp_d      = tp_q;
        tp_d.stop = stopped_i;
        clr_vec   = '0;
        mask_wr   = 1'b0;
        if (reg_we_i) begin
            if (sel == SEL_STATUS) begin
                clr_vec = reg_wdata_i[EVT_W-1:0];
            end else begin
                mask_wr = 1'b1;
            end
        end
        if (sel == SEL_STATUS) begin
            rd_mux = {tp_q.stop, status_bits};
        end else begin
            rd_mux = {1'b0, mask_bits};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tp_q <= '{stop: 1'b1};
        end else begin
            tp_q <= tp_d;
        end
    end

    irq_evt_latch #(.W(EVT_W)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (evt_i),
        .clr_i    (clr_vec),
        .status_o (status_bits)
    );

    irq_mask_reg #(.W(EVT_W)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (mask_wr),
        .wdata_i (reg_wdata_i[EVT_W-1:0]),
        .mask_o  (mask_bits)
    );

    irq_req_gen #(.W(EVT_W)) u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .status_i (status_bits),
        .mask_i   (mask_bits),
        .irq_o    (irq_o)
    );

    assign reg_rdata_o = rd_mux;

    // R9: stopped bit is the input delayed by one edge
    a_r9_stop_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (tp_q.stop == $past(stopped_i)));

endmodule

// File: tb/irq_status_ctrl_bench.sv
module irq_status_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] evt = '0;
    logic       stopped = 1'b1;
    logic       addr = 1'b0;
    logic       we = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [6:0] m_st;
    logic [6:0] m_mask;
    logic       m_stop;
    logic       m_irq;

    always #4 clk = ~clk;

    irq_status_ctrl u_irq_status_ctrl (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .stopped_i(stopped),
        .reg_addr_i(addr), .reg_we_i(we), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_o(irq)
    );

    function automatic logic [6:0] nxt_status(logic [6:0] st, logic [6:0] e,
                                              logic w, logic a, logic [7:0] d);
        logic [6:0] clr = (w && !a) ? d[6:0] : 7'h00;
        return (st & ~clr) | e;
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        addr = 1'b0;
        #1 chk({tag, " status"}, rdata, {m_stop, m_st});
        addr = 1'b1;
        #1 chk({tag, " mask"}, rdata, {1'b0, m_mask});
        chk({tag, " irq"}, {7'h00, irq}, {7'h00, m_irq});
    endtask

    task automatic step(logic [6:0] e, logic w, logic a, logic [7:0] d, logic s);
        evt = e; we = w; addr = a; wdata = d; stopped = s;
        @(posedge clk);
        m_irq  = |(m_st & m_mask);
        m_st   = nxt_status(m_st, e, w, a, d);
        if (w && a) m_mask = d[6:0];
        m_stop = s;
        @(negedge clk);
        evt = '0; we = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        m_st = '0; m_mask = '0; m_stop = 1'b1; m_irq = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_all("R1 reset");

        step(7'h00, 0, 0, 8'h00, 0);
        check_all("R9 stopped low");
        step(7'h05, 0, 0, 8'h00, 0);
        check_all("R2 set");
        step(7'h00, 0, 0, 8'h00, 0);
        check_all("R8 R7 pending unmasked");
        step(7'h00, 1, 1, 8'hFF, 0);
        check_all("R5 mask bit7 zero");
        step(7'h00, 0, 0, 8'h00, 0);
        check_all("R6 irq lag");
        step(7'h00, 1, 0, 8'h01, 0);
        check_all("R3 clear one");
        step(7'h04, 1, 0, 8'h04, 0);
        check_all("R4 set wins");
        step(7'h00, 0, 0, 8'h00, 1);
        check_all("R9 stopped high");
        step(7'h00, 1, 0, 8'hFF, 1);
        check_all("R3 R9 clear all keeps bit7");
        step(7'h00, 0, 0, 8'h00, 1);
        check_all("R6 irq falls");
        step(7'h00, 1, 1, 8'h00, 1);
        step(7'h7F, 0, 0, 8'h00, 1);
        step(7'h00, 0, 0, 8'h00, 1);
        check_all("R7 zero mask");

        for (int i = 0; i < 600; i++) begin
            logic [6:0] e = 7'($urandom) & 7'($urandom);
            logic       w = ($urandom % 3) == 0;
            logic       a = 1'($urandom);
            logic [7:0] d = 8'($urandom);
            logic       s = ($urandom % 5) != 0 ? stopped : ~stopped;
            step(e, w, a, d, s);
            check_all("R6 random");
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule